// File: doc/BRIEF.md
# Multiplexed Address Capture Latch

This block sits on the external side of a bus where the low address bits share pins with the data lines. During the address phase an address-strobe pulse (ALE) is driven high. The block keeps a short history of the shared lines and the dedicated upper address lines. When the strobe falls, it stores the full address, so the rest of the system sees a stable 20-bit address and a valid flag for the whole access, even though the shared pins have moved on to carry data.

Which bits travel on the shared pins depends on the bus width. On a byte-wide bus the eight shared lines carry the eight lowest address bits. On a halfword-wide bus they carry bits one to eight, and bit zero has a pin of its own. A two-bit configuration field and the identity of the chip-select area being accessed decide whether the current access uses the multiplexed scheme at all. When it does not, the block passes the address straight through and ignores the strobe.

The strobe is asynchronous to the block clock. It passes through a synchronizer, and its falling edge becomes a one-clock pulse. The captured address is the bus state at the last clock sample taken while the strobe was still high, so data driven onto the shared lines right after the strobe falls can never corrupt the capture.

Top module: `muxaddr_latch`

## Requirements
- R1: After reset, the address output is all zeros and the valid flag is low.
- R2: In a multiplexed area, the address is stored only on a falling edge of the strobe. The stored value is the inputs as sampled at the last clock edge that still saw the strobe high. It appears on the output no later than six clocks after the strobe falls.
- R3: Byte-wide mode (width select 0): output bits 7:0 come from shared lines 7:0, and output bits 19:8 come from upper lines 19:8. The bit-zero pin is ignored.
- R4: Halfword-wide mode (width select 1): output bit 0 comes from the bit-zero pin, bits 8:1 from shared lines 7:0, and bits 19:9 from upper lines 19:9. Upper line 8 is ignored.
- R5: In a multiplexed area, the output address does not change between falling edges, whatever the shared, upper and bit-zero inputs do.
- R6: With the area field at 2'b11, every chip-select area is multiplexed.
- R7: With the area field at 2'b01, only area number 2 is multiplexed. With 2'b10, only area number 1 is multiplexed. In both cases every other area passes through.
- R8: With the area field at 2'b00, or in an area that is not multiplexed, the output follows the mapped inputs one clock later, and strobe edges have no effect.
- R9: The valid flag goes high one clock after a capture made while the chip select is active. It goes low one clock after the chip select drops. In a multiplexed area, re-asserting the chip select without a new capture leaves it low. In pass-through it follows the chip select one clock later.
- R10: A rising edge of the strobe stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_shared_i | input | 8 | Shared address/data lines |
| addr_hi_i | input | 12 | Dedicated upper address lines, bits 19:8 |
| addr_bit0_i | input | 1 | Separate bit-zero address pin (halfword mode) |
| ale_i | input | 1 | Address strobe, asynchronous |
| wide_bus_i | input | 1 | 1 = halfword-wide bus, 0 = byte-wide bus |
| mux_area_sel_i | input | 2 | Multiplexed-area field |
| cs_active_i | input | 1 | A chip select is asserted |
| cs_area_i | input | 2 | Number of the chip-select area being accessed |
| addr_o | output | 20 | Latched or passed-through address |
| addr_valid_o | output | 1 | Address valid for the current access |

## Verification
The hardest case to reach from the ports is a capture that has to ignore a change arriving at the same moment as the strobe edge. This is the point where the delayed input history must line up exactly with the synchronizer. The bench drives the strobe low and scrambles the shared and upper lines at the same instant, then expects the pre-edge address. A second hard case is a mode change from pass-through to a multiplexed area with no strobe edge. The bench changes only the area number, then moves the inputs and expects the output to freeze at the last passed value.

// File: rtl/muxaddr_pkg.sv
package muxaddr_pkg;
   typedef enum logic [1:0] {
      MUX_NONE  = 2'b00,
      MUX_AREA2 = 2'b01,
      MUX_AREA1 = 2'b10,
      MUX_ALL   = 2'b11
   } mux_sel_e;

   localparam int unsigned DEF_ADDR_W   = 20;
   localparam int unsigned DEF_SHARED_W = 8;
   localparam int unsigned DEF_SYNC     = 2;
endpackage

// File: rtl/mal_ale_sync.sv
module mal_ale_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ale_i,
   output logic fall_o
);
   logic [STAGES:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("mal_ale_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], ale_i};
   end

   assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/mal_delay.sv
module mal_delay #(
   parameter int unsigned WIDTH = 21,
   parameter int unsigned DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] dout_o
);
   logic [WIDTH-1:0] stage_q [DEPTH];

   generate
      if (DEPTH < 1) begin : g_bad
         $error("mal_delay: DEPTH must be at least 1");
      end
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= din_i;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout_o = stage_q[DEPTH-1];
endmodule

// File: rtl/mal_area_decode.sv
module mal_area_decode
   import muxaddr_pkg::*;
#(
   parameter int unsigned AREA_W   = 2,
   parameter int unsigned AREA_SEL_LO = 2,
   parameter int unsigned AREA_SEL_HI = 1
) (
   input  logic [1:0]        sel_i,
   input  logic [AREA_W-1:0] area_i,
   output logic              is_mux_o
);
   mux_sel_e sel;

   generate
      if ((AREA_SEL_LO >= (1 << AREA_W)) || (AREA_SEL_HI >= (1 << AREA_W))) begin : g_bad
         $error("mal_area_decode: area numbers exceed AREA_W");
      end
   endgenerate

   always_comb begin
      sel = mux_sel_e'(sel_i);
      unique case (sel)
         MUX_NONE:  is_mux_o = 1'b0;
         MUX_AREA2: is_mux_o = (area_i == AREA_W'(AREA_SEL_LO));
         MUX_AREA1: is_mux_o = (area_i == AREA_W'(AREA_SEL_HI));
         MUX_ALL:   is_mux_o = 1'b1;
         default:   is_mux_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/muxaddr_latch.sv
module muxaddr_latch
   import muxaddr_pkg::*;
#(
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned SHARED_W    = DEF_SHARED_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC,
   parameter int unsigned AREA_W      = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SHARED_W-1:0]        ad_shared_i,
   input  logic [ADDR_W-1:SHARED_W]   addr_hi_i,
   input  logic                       addr_bit0_i,
   input  logic                       ale_i,
   input  logic                       wide_bus_i,
   input  logic [1:0]                 mux_area_sel_i,
   input  logic                       cs_active_i,
   input  logic [AREA_W-1:0]          cs_area_i,
   output logic [ADDR_W-1:0]          addr_o,
   output logic                       addr_valid_o
);
   localparam int unsigned HI_W    = ADDR_W - SHARED_W;
   localparam int unsigned BUNDLE_W = ADDR_W + 1;
   localparam int unsigned HIST_D  = SYNC_STAGES + 1;

   generate
      if (HI_W < 2) begin : g_bad
         $error("muxaddr_latch: ADDR_W must exceed SHARED_W by at least 2");
      end
   endgenerate

   logic [BUNDLE_W-1:0] bundle_now, bundle_old;
   logic [ADDR_W-1:0]   map_now, map_old;
   logic                ale_fall, area_mux, pass_mode;
   logic [ADDR_W-1:0]   addr_q;
   logic                valid_q;

   assign bundle_now = {addr_bit0_i, addr_hi_i, ad_shared_i};

   mal_ale_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .fall_o(ale_fall));

   mal_delay #(.WIDTH(BUNDLE_W), .DEPTH(HIST_D)) u_hist (
      .clk(clk), .rst_n(rst_n), .din_i(bundle_now), .dout_o(bundle_old));

   mal_area_decode #(.AREA_W(AREA_W)) u_area (
      .sel_i(mux_area_sel_i), .area_i(cs_area_i), .is_mux_o(area_mux));

   function automatic logic [ADDR_W-1:0] map_bundle(input logic [BUNDLE_W-1:0] b,
                                                    input logic wide);
      logic [SHARED_W-1:0]  shr;
      logic [HI_W-1:0]      hi;
      logic                 b0;
      shr = b[SHARED_W-1:0];
      hi  = b[ADDR_W-1:SHARED_W];
      b0  = b[ADDR_W];
      if (wide) map_bundle = {hi[HI_W-1:1], shr, b0};
      else      map_bundle = {hi, shr};
   endfunction

   assign map_now   = map_bundle(bundle_now, wide_bus_i);
   assign map_old   = map_bundle(bundle_old, wide_bus_i);
   assign pass_mode = ~area_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         if (pass_mode)     addr_q <= map_now;
         else if (ale_fall) addr_q <= map_old;
         valid_q <= cs_active_i & (pass_mode | ale_fall | valid_q);
      end
   end

   assign addr_o       = addr_q;
   assign addr_valid_o = valid_q;

   p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (area_mux && !ale_fall) |=> $stable(addr_o));
   p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active_i |=> !addr_valid_o);
   p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (area_mux && ale_fall && cs_active_i) |=> addr_valid_o);
   p_pass_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_mode && cs_active_i) |=> addr_valid_o);
   p_all_mux_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_area_sel_i == 2'b11) |-> area_mux);
endmodule

// File: tb/muxaddr_latch_tb_top.sv
module muxaddr_latch_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ad_shared;
   logic [19:8] addr_hi;
   logic        addr_bit0, ale, wide_bus, cs_active;
   logic [1:0]  mux_sel, cs_area;
   logic [19:0] addr;
   logic        valid;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   muxaddr_latch dut_i (
      .clk(clk), .rst_n(rst_n), .ad_shared_i(ad_shared), .addr_hi_i(addr_hi),
      .addr_bit0_i(addr_bit0), .ale_i(ale), .wide_bus_i(wide_bus),
      .mux_area_sel_i(mux_sel), .cs_active_i(cs_active), .cs_area_i(cs_area),
      .addr_o(addr), .addr_valid_o(valid));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_addr(input logic [19:0] a);
      if (wide_bus) begin
         ad_shared = a[8:1];
         addr_bit0 = a[0];
         addr_hi   = {a[19:9], ~a[8]};
      end else begin
         ad_shared = a[7:0];
         addr_bit0 = ~a[0];
         addr_hi   = a[19:8];
      end
   endtask

   task automatic strobe_capture(input logic [19:0] a);
      drive_addr(a);
      ale = 1'b1;
      clocks(4);
      ale = 1'b0;
      ad_shared = ~ad_shared;
      addr_hi   = ~addr_hi;
      addr_bit0 = ~addr_bit0;
      clocks(6);
   endtask

   task automatic t_reset;
      chk("R1 addr after reset", {12'h0, addr}, 32'h0);
      chk("R1 valid after reset", {31'h0, valid}, 32'h0);
   endtask

   task automatic t_narrow;
      wide_bus = 1'b0; mux_sel = 2'b11; cs_area = 2'd0; cs_active = 1'b1;
      strobe_capture(20'hA5_C3_7);
      chk("R3 R2 narrow capture", {12'h0, addr}, {12'h0, 20'hA5C37});
      chk("R9 valid after capture", {31'h0, valid}, 32'h1);
      strobe_capture(20'h0_12_FF);
      chk("R3 narrow second capture", {12'h0, addr}, {12'h0, 20'h012FF});
   endtask

   task automatic t_wide;
      wide_bus = 1'b1; mux_sel = 2'b11; cs_area = 2'd3;
      strobe_capture(20'h5_A1_01);
      chk("R4 wide capture odd", {12'h0, addr}, {12'h0, 20'h5A101});
      strobe_capture(20'hF_FE_FE);
      chk("R4 wide capture even", {12'h0, addr}, {12'h0, 20'hFFEFE});
   endtask

   task automatic t_hold;
      wide_bus = 1'b0; mux_sel = 2'b11;
      strobe_capture(20'h3_33_33);
      drive_addr(20'h4_44_44);
      clocks(5);
      chk("R5 hold while strobe low", {12'h0, addr}, {12'h0, 20'h33333});
      ale = 1'b1;
      clocks(6);
      chk("R10 rising edge stores nothing", {12'h0, addr}, {12'h0, 20'h33333});
      drive_addr(20'h5_55_55);
      clocks(3);
      chk("R5 hold while strobe high", {12'h0, addr}, {12'h0, 20'h33333});
      ale = 1'b0;
      drive_addr(20'h6_66_66);
      clocks(6);
      chk("R2 pre-edge value captured", {12'h0, addr}, {12'h0, 20'h55555});
   endtask

   task automatic t_areas;
      wide_bus = 1'b0; cs_active = 1'b1;
      mux_sel = 2'b01; cs_area = 2'd1;
      drive_addr(20'h1_00_01);
      clocks(1);
      chk("R7 sel01 area1 passes", {12'h0, addr}, {12'h0, 20'h10001});
      cs_area = 2'd2;
      clocks(1);
      drive_addr(20'h2_00_02);
      clocks(4);
      chk("R7 sel01 area2 multiplexed holds", {12'h0, addr}, {12'h0, 20'h10001});
      strobe_capture(20'h2_22_22);
      chk("R7 sel01 area2 captures", {12'h0, addr}, {12'h0, 20'h22222});
      mux_sel = 2'b10; cs_area = 2'd2;
      drive_addr(20'h3_00_03);
      clocks(1);
      chk("R7 sel10 area2 passes", {12'h0, addr}, {12'h0, 20'h30003});
      cs_area = 2'd1;
      clocks(1);
      drive_addr(20'h4_00_04);
      clocks(4);
      chk("R7 sel10 area1 multiplexed holds", {12'h0, addr}, {12'h0, 20'h30003});
      mux_sel = 2'b11; cs_area = 2'd0;
      clocks(1);
      drive_addr(20'h5_00_05);
      clocks(4);
      chk("R6 sel11 area0 multiplexed holds", {12'h0, addr}, {12'h0, 20'h30003});
   endtask

   task automatic t_pass;
      mux_sel = 2'b00; wide_bus = 1'b1; cs_area = 2'd3;
      drive_addr(20'hB_EE_F1);
      clocks(1);
      chk("R8 pass one clock later", {12'h0, addr}, {12'h0, 20'hBEEF1});
      ale = 1'b1;
      clocks(4);
      ale = 1'b0;
      drive_addr(20'hC_0F_FE);
      clocks(1);
      chk("R8 strobe ignored in pass", {12'h0, addr}, {12'h0, 20'hC0FFE});
      cs_active = 1'b0;
      clocks(1);
      chk("R9 pass valid drops", {31'h0, valid}, 32'h0);
      cs_active = 1'b1;
      clocks(1);
      chk("R9 pass valid follows cs", {31'h0, valid}, 32'h1);
   endtask

   task automatic t_valid;
      mux_sel = 2'b11; wide_bus = 1'b0; cs_active = 1'b1;
      strobe_capture(20'h7_77_77);
      chk("R9 valid set by capture", {31'h0, valid}, 32'h1);
      cs_active = 1'b0;
      clocks(1);
      chk("R9 valid clears after cs drop", {31'h0, valid}, 32'h0);
      cs_active = 1'b1;
      clocks(3);
      chk("R9 valid stays low without capture", {31'h0, valid}, 32'h0);
      strobe_capture(20'h8_88_88);
      chk("R9 valid set again", {31'h0, valid}, 32'h1);
   endtask

   initial begin
      ad_shared = '0; addr_hi = '0; addr_bit0 = 1'b0; ale = 1'b0;
      wide_bus = 1'b0; mux_sel = 2'b11; cs_active = 1'b0; cs_area = 2'd0;
      clocks(3);
      t_reset();
      rst_n = 1'b1;
      clocks(2);
      t_narrow();
      t_wide();
      t_hold();
      t_areas();
      t_pass();
      t_valid();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule